// File: doc/BRIEF.md
# Embedded-Sync Digital Video Output Formatter

This block turns a stream of 4:2:2 co-sited pixels into a continuous byte-parallel video signal, one byte per clock, with the line and field timing carried in the stream itself. Timing is free-running and internal. A line counter and a byte counter step through a raster whose total lines, total pixels per line, active pixels, blank lines per field, second-field start line and scan mode (interlaced or progressive) are all input settings. Every line opens with a start-of-active timing code and closes its active region with an end-of-active timing code. The active region is filled with pixel data pulled from an upstream source. Horizontal blanking and vertical-blanking lines carry the blank-level pattern. Separate horizontal and frame sync outputs and two interrupt pulses come out aligned with the byte stream.

The upstream source answers a one-cycle pixel request in the same cycle. It presents the pixel's chroma byte and luma byte together on `pix_data` as {chroma, luma}. It supplies Cb for even pixels and Cr for odd pixels, so the stream comes out in the order Cb, Y, Cr, Y. All geometry settings are sampled into shadow registers when a field begins. Software can therefore rewrite them at any time without tearing the field in progress.

Top module: `sdv_out_top`

## Requirements
- R1: A line is 2 × `cfg_pix_total` bytes, with byte positions numbered from 0. Bytes 0..3 are the start code FF 00 00 XY with H=0. The next 2 × `cfg_pix_active` bytes form the active window. The four bytes after that are the end code FF 00 00 XY with H=1. Every byte after the end code is blanking: 0x80 at even byte positions and 0x10 at odd ones.
- R2: The fourth code byte XY is {1, F, V, H, V^H, F^H, F^V, F^V^H}, with bit 7 first.
- R3: In interlaced mode, lines 0..`cfg_f2_start`−1 form field one (F=0) and the remaining lines form field two (F=1). In progressive mode, every line has F=0. The first `cfg_vblank` lines of each field have V=1. On those lines the active window holds the blank pattern and no pixel is requested.
- R4: On a line with V=0, `pix_req` is high in the cycle the raster is at each even offset of the active window, and `pix_data` is consumed in that cycle. The output then carries that pixel's chroma byte followed by its luma byte. Each frame therefore requests exactly (lines with V=0) × `cfg_pix_active` pixels.
- R5: Active bytes are clipped: 0x00 becomes 0x01 and 0xFF becomes 0xFE. Outside the timing codes, 0x00 and 0xFF never appear.
- R6: `vo_hsync` is high on end-code and blanking bytes and low on start-code and active bytes. `vo_fsync` is high on every byte of line 0.
- R7: When `irq_field_en` is high, `irq_field` pulses for one cycle alongside the last byte of each field. When it is low, `irq_field` stays low.
- R8: When `irq_line_en` is high, `irq_line` pulses for one cycle alongside the first byte of line `cfg_irq_line`. When it is low, `irq_line` stays low.
- R9: The geometry inputs and `cfg_irq_line` take effect only from the next field start. A change in mid-field leaves the rest of that field unchanged.
- R10: While `rst` is high, `vo_data` is 0x10 and both syncs and both interrupts are low. The first output byte after reset is the start code of line 0. `vo_data` shows each raster position one cycle after the raster reaches it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_lines_total | input | 12 | Lines per frame |
| cfg_f2_start | input | 12 | First line of field two (interlaced) |
| cfg_vblank | input | 12 | Blank lines at the top of each field |
| cfg_pix_total | input | 12 | Pixels per line including blanking |
| cfg_pix_active | input | 12 | Active pixels per line |
| cfg_interlace | input | 1 | 1 = two fields per frame |
| cfg_irq_line | input | 12 | Line that raises the line interrupt |
| irq_field_en | input | 1 | Enables the end-of-field interrupt |
| irq_line_en | input | 1 | Enables the line interrupt |
| pix_data | input | 16 | {chroma, luma} of the requested pixel |
| pix_req | output | 1 | Pixel request, consumed in the same cycle |
| vo_data | output | 8 | Output byte stream |
| vo_hsync | output | 1 | Horizontal sync |
| vo_fsync | output | 1 | Frame sync |
| irq_field | output | 1 | End-of-field interrupt pulse |
| irq_line | output | 1 | Line interrupt pulse |

## Verification
The assertions assume a consistent geometry: `cfg_pix_total` is at least `cfg_pix_active` + 4, a frame has at least two lines, `cfg_f2_start` lies strictly inside the frame in interlaced mode, and the blank line count is smaller than each field. Under those conditions the only bytes that can be 0xFF or 0x00 belong to a code, so a code prefix can be recognised from the byte history alone. The assertions also assume the upstream source returns data in the request cycle. The stimulus uses only geometries that meet these limits, including one with no horizontal blanking at all and one with an odd active pixel count. It applies its single mid-field change to the total pixel count, and the new value still leaves room for both codes.

// File: rtl/sdv_pkg.sv
package sdv_pkg;

  typedef enum logic [1:0] {
    RG_SAV = 2'd0,
    RG_ACT = 2'd1,
    RG_EAV = 2'd2,
    RG_HBL = 2'd3
  } region_e;

  localparam logic [7:0] BLANK_CHROMA = 8'h80;
  localparam logic [7:0] BLANK_LUMA   = 8'h10;
  localparam logic [7:0] CODE_LEAD    = 8'hFF;
  localparam logic [7:0] CODE_ZERO    = 8'h00;

  function automatic logic [7:0] trs_word(input logic f, input logic v, input logic h);
    logic [7:0] w;
    w = {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    return w;
  endfunction

  function automatic logic [7:0] clip_sample(input logic [7:0] d);
    logic [7:0] r;
    r = d;
    if (d == 8'h00) r = 8'h01;
    if (d == 8'hFF) r = 8'hFE;
    return r;
  endfunction

endpackage

// File: rtl/sdv_geom_shadow.sv
module sdv_geom_shadow #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] cfg_lines_total,
  input  logic [CW-1:0] cfg_f2_start,
  input  logic [CW-1:0] cfg_vblank,
  input  logic [CW-1:0] cfg_pix_total,
  input  logic [CW-1:0] cfg_pix_active,
  input  logic          cfg_interlace,
  input  logic [CW-1:0] cfg_irq_line,
  output logic [CW-1:0] s_lines_total,
  output logic [CW-1:0] s_f2_start,
  output logic [CW-1:0] s_vblank,
  output logic [CW-1:0] s_pix_total,
  output logic [CW-1:0] s_pix_active,
  output logic          s_interlace,
  output logic [CW-1:0] s_irq_line
);

  // Captured at reset and on the last byte of every field.
  always_ff @(posedge clk) begin
    if (rst || load) begin
      s_lines_total <= cfg_lines_total;
      s_f2_start    <= cfg_f2_start;
      s_vblank      <= cfg_vblank;
      s_pix_total   <= cfg_pix_total;
      s_pix_active  <= cfg_pix_active;
      s_interlace   <= cfg_interlace;
      s_irq_line    <= cfg_irq_line;
    end
  end

endmodule

// File: rtl/sdv_raster.sv
module sdv_raster #(
  parameter int CW = 12,
  localparam int HW = CW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] s_lines_total,
  input  logic [CW-1:0] s_f2_start,
  input  logic [CW-1:0] s_vblank,
  input  logic [CW-1:0] s_pix_total,
  input  logic          s_interlace,
  output logic [HW-1:0] hc,
  output logic [CW-1:0] line,
  output logic          in_f2,
  output logic          vblank,
  output logic          field_end
);

  logic [HW-1:0] h_max;
  logic          h_last;
  logic          line_last;
  logic          f1_last;
  logic [CW-1:0] line_in_field;

  always_comb begin
    h_max     = {s_pix_total, 1'b0} - HW'(1);
    h_last    = (hc == h_max);
    line_last = (line == s_lines_total - CW'(1));
    f1_last   = s_interlace && (line == s_f2_start - CW'(1));
    field_end = h_last && (line_last || f1_last);
  end

  always_comb begin
    in_f2         = s_interlace && (line >= s_f2_start);
    line_in_field = in_f2 ? (line - s_f2_start) : line;
    vblank        = (line_in_field < s_vblank);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hc   <= '0;
      line <= '0;
    end else if (h_last) begin
      hc   <= '0;
      line <= line_last ? '0 : line + CW'(1);
    end else begin
      hc   <= hc + HW'(1);
    end
  end

endmodule

// File: rtl/sdv_byte_fmt.sv
module sdv_byte_fmt
  import sdv_pkg::*;
#(
  parameter int CW = 12,
  localparam int HW = CW + 1,
  localparam int XW = CW + 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [HW-1:0] hc,
  input  logic [CW-1:0] line,
  input  logic          in_f2,
  input  logic          vblank,
  input  logic          field_end,
  input  logic [CW-1:0] s_pix_active,
  input  logic [CW-1:0] s_irq_line,
  input  logic          irq_field_en,
  input  logic          irq_line_en,
  input  logic [15:0]   pix_data,
  output logic          pix_req,
  output logic [7:0]    vo_data,
  output logic          vo_hsync,
  output logic          vo_fsync,
  output logic          irq_field,
  output logic          irq_line
);

  logic [XW-1:0] hx;
  logic [XW-1:0] act_end;
  logic [XW-1:0] eav_end;
  region_e       region;
  logic [1:0]    cidx;
  logic [7:0]    code_byte;
  logic [7:0]    blank_byte;
  logic [7:0]    luma_q;
  logic [7:0]    byte_d;

  always_comb begin
    hx      = XW'(hc);
    act_end = XW'({s_pix_active, 1'b0}) + XW'(4);
    eav_end = act_end + XW'(4);
    if (hx < XW'(4))         region = RG_SAV;
    else if (hx < act_end)   region = RG_ACT;
    else if (hx < eav_end)   region = RG_EAV;
    else                     region = RG_HBL;
  end

  always_comb begin
    cidx = (region == RG_EAV) ? (hx[1:0] - act_end[1:0]) : hx[1:0];
    case (cidx)
      2'd0:    code_byte = CODE_LEAD;
      2'd3:    code_byte = trs_word(in_f2, vblank, region == RG_EAV);
      default: code_byte = CODE_ZERO;
    endcase
    blank_byte = hx[0] ? BLANK_LUMA : BLANK_CHROMA;
  end

  // Active window starts at an even position, so hx[0] marks the luma slot.
  assign pix_req = (region == RG_ACT) && !vblank && !hx[0];

  always_ff @(posedge clk) begin
    if (rst)          luma_q <= BLANK_LUMA;
    else if (pix_req) luma_q <= pix_data[7:0];
  end

  always_comb begin
    case (region)
      RG_SAV, RG_EAV: byte_d = code_byte;
      RG_ACT: begin
        if (vblank)      byte_d = blank_byte;
        else if (hx[0])  byte_d = clip_sample(luma_q);
        else             byte_d = clip_sample(pix_data[15:8]);
      end
      default:        byte_d = blank_byte;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vo_data   <= BLANK_LUMA;
      vo_hsync  <= 1'b0;
      vo_fsync  <= 1'b0;
      irq_field <= 1'b0;
      irq_line  <= 1'b0;
    end else begin
      vo_data   <= byte_d;
      vo_hsync  <= (region == RG_EAV) || (region == RG_HBL);
      vo_fsync  <= (line == '0);
      irq_field <= irq_field_en && field_end;
      irq_line  <= irq_line_en && (line == s_irq_line) && (hc == '0);
    end
  end

endmodule

// File: rtl/sdv_out_top.sv
module sdv_out_top #(
  parameter int CW = 12,
  localparam int HW = CW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cfg_lines_total,
  input  logic [CW-1:0] cfg_f2_start,
  input  logic [CW-1:0] cfg_vblank,
  input  logic [CW-1:0] cfg_pix_total,
  input  logic [CW-1:0] cfg_pix_active,
  input  logic          cfg_interlace,
  input  logic [CW-1:0] cfg_irq_line,
  input  logic          irq_field_en,
  input  logic          irq_line_en,
  input  logic [15:0]   pix_data,
  output logic          pix_req,
  output logic [7:0]    vo_data,
  output logic          vo_hsync,
  output logic          vo_fsync,
  output logic          irq_field,
  output logic          irq_line
);

  logic [CW-1:0] s_lines_total, s_f2_start, s_vblank;
  logic [CW-1:0] s_pix_total, s_pix_active, s_irq_line;
  logic          s_interlace;
  logic [HW-1:0] hc;
  logic [CW-1:0] line;
  logic          in_f2, vblank, field_end;

  sdv_geom_shadow #(.CW(CW)) u_shadow (
    .clk(clk), .rst(rst), .load(field_end),
    .cfg_lines_total(cfg_lines_total), .cfg_f2_start(cfg_f2_start),
    .cfg_vblank(cfg_vblank), .cfg_pix_total(cfg_pix_total),
    .cfg_pix_active(cfg_pix_active), .cfg_interlace(cfg_interlace),
    .cfg_irq_line(cfg_irq_line),
    .s_lines_total(s_lines_total), .s_f2_start(s_f2_start),
    .s_vblank(s_vblank), .s_pix_total(s_pix_total),
    .s_pix_active(s_pix_active), .s_interlace(s_interlace),
    .s_irq_line(s_irq_line)
  );

  sdv_raster #(.CW(CW)) u_raster (
    .clk(clk), .rst(rst),
    .s_lines_total(s_lines_total), .s_f2_start(s_f2_start),
    .s_vblank(s_vblank), .s_pix_total(s_pix_total),
    .s_interlace(s_interlace),
    .hc(hc), .line(line), .in_f2(in_f2), .vblank(vblank),
    .field_end(field_end)
  );

  sdv_byte_fmt #(.CW(CW)) u_fmt (
    .clk(clk), .rst(rst), .hc(hc), .line(line), .in_f2(in_f2),
    .vblank(vblank), .field_end(field_end),
    .s_pix_active(s_pix_active), .s_irq_line(s_irq_line),
    .irq_field_en(irq_field_en), .irq_line_en(irq_line_en),
    .pix_data(pix_data), .pix_req(pix_req), .vo_data(vo_data),
    .vo_hsync(vo_hsync), .vo_fsync(vo_fsync),
    .irq_field(irq_field), .irq_line(irq_line)
  );

endmodule

// File: rtl/sdv_out_chk.sv
module sdv_out_chk (
  input logic       clk,
  input logic       rst,
  input logic       pix_req,
  input logic [7:0] vo_data,
  input logic       vo_hsync,
  input logic       vo_fsync,
  input logic       irq_field,
  input logic       irq_line,
  input logic       irq_field_en
);

  AST_LEAD_THEN_ZERO: assert property (@(posedge clk) disable iff (rst)
    (vo_data == 8'hFF) |=> (vo_data == 8'h00)); // R1

  AST_CODE_PARITY: assert property (@(posedge clk) disable iff (rst)
    ($past(vo_data, 3) == 8'hFF && $past(vo_data, 2) == 8'h00 && $past(vo_data, 1) == 8'h00)
    |-> (vo_data[7] && vo_data[3] == (vo_data[5] ^ vo_data[4])
         && vo_data[2] == (vo_data[6] ^ vo_data[4])
         && vo_data[1] == (vo_data[6] ^ vo_data[5])
         && vo_data[0] == (vo_data[6] ^ vo_data[5] ^ vo_data[4]))); // R2

  AST_REQ_IN_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    pix_req |=> !vo_hsync); // R4

  AST_FSYNC_AT_CODE: assert property (@(posedge clk) disable iff (rst)
    $rose(vo_fsync) |-> (vo_data == 8'hFF)); // R6

  AST_FIELD_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    irq_field |=> !irq_field); // R7

  AST_FIELD_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq_field |-> $past(irq_field_en)); // R7

  AST_LINE_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    irq_line |=> !irq_line); // R8

endmodule

bind sdv_out_top sdv_out_chk u_chk (
  .clk(clk), .rst(rst), .pix_req(pix_req), .vo_data(vo_data),
  .vo_hsync(vo_hsync), .vo_fsync(vo_fsync), .irq_field(irq_field),
  .irq_line(irq_line), .irq_field_en(irq_field_en)
);

// File: tb/sdv_out_top_test.sv
module sdv_out_top_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] cfg_lines_total, cfg_f2_start, cfg_vblank;
  logic [11:0] cfg_pix_total, cfg_pix_active, cfg_irq_line;
  logic        cfg_interlace, irq_field_en, irq_line_en;
  logic [15:0] pix_data;
  logic        pix_req, vo_hsync, vo_fsync, irq_field, irq_line;
  logic [7:0]  vo_data;
  int          checks = 0;
  int          errors = 0;
  int          pcnt = 0;

  always #2 clk = ~clk;

  sdv_out_top uut (
    .clk(clk), .rst(rst), .cfg_lines_total(cfg_lines_total),
    .cfg_f2_start(cfg_f2_start), .cfg_vblank(cfg_vblank),
    .cfg_pix_total(cfg_pix_total), .cfg_pix_active(cfg_pix_active),
    .cfg_interlace(cfg_interlace), .cfg_irq_line(cfg_irq_line),
    .irq_field_en(irq_field_en), .irq_line_en(irq_line_en),
    .pix_data(pix_data), .pix_req(pix_req), .vo_data(vo_data),
    .vo_hsync(vo_hsync), .vo_fsync(vo_fsync),
    .irq_field(irq_field), .irq_line(irq_line)
  );

  // {lines, f2_start, vblank, pix_total, pix_active, irq_line, interlace}
  typedef struct packed {
    logic [11:0] lines, f2, vbl, pix, act, irql;
    logic        intl;
  } geom_t;

  localparam int NCFG = 4;
  localparam geom_t TBL [NCFG] = '{
    '{12'd7, 12'd4, 12'd1, 12'd10, 12'd4, 12'd2, 1'b1},
    '{12'd5, 12'd0, 12'd2, 12'd8,  12'd4, 12'd4, 1'b0},   // no h blanking
    '{12'd6, 12'd3, 12'd1, 12'd12, 12'd6, 12'd0, 1'b1},
    '{12'd4, 12'd2, 12'd0, 12'd9,  12'd5, 12'd3, 1'b1}    // odd active count
  };

  function automatic int pat_c(int n); return (n * 85) & 255; endfunction
  function automatic int pat_y(int n); return (n * 51) & 255; endfunction
  function automatic int clipb(int d);
    if (d == 0) return 1;
    if (d == 255) return 254;
    return d;
  endfunction
  function automatic int codeb(int idx, bit f, bit v, bit h);
    if (idx == 0) return 255;
    if (idx < 3) return 0;
    return 128 + f*64 + v*32 + h*16 + (v^h)*8 + (f^h)*4 + (f^v)*2 + (f^v^h);
  endfunction

  // Upstream source: answers a request in the same cycle.
  assign pix_data = {8'(pat_c(pcnt)), 8'(pat_y(pcnt))};
  always @(posedge clk) begin
    if (rst) pcnt <= 0;
    else if (pix_req) pcnt <= pcnt + 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic run(input geom_t g, input int frames, input bit en,
                     input bit chg, input int chg_pix);
    int ep, l, bpl, a2, e, raw;
    bit f, v, done;
    int m_lines, m_f2, m_vbl, m_pix, m_act, m_irql;
    bit m_intl;
    string tg;
    rst = 1'b1;
    cfg_lines_total = g.lines; cfg_f2_start = g.f2; cfg_vblank = g.vbl;
    cfg_pix_total = g.pix; cfg_pix_active = g.act; cfg_irq_line = g.irql;
    cfg_interlace = g.intl; irq_field_en = en; irq_line_en = en;
    repeat (3) @(negedge clk);
    chk(vo_data == 8'h10 && !vo_hsync && !vo_fsync && !irq_field && !irq_line,
        "R10 reset state", int'(vo_data), 16);
    rst = 1'b0;
    ep = 0;
    m_lines = 0; m_f2 = 0; m_vbl = 0; m_pix = 0; m_act = 0; m_irql = 0; m_intl = 0;
    for (int fr = 0; fr < frames; fr++) begin
      l = 0;
      done = 0;
      while (!done) begin
        if (l == 0 || (m_intl && l == m_f2)) begin
          m_lines = int'(cfg_lines_total); m_f2 = int'(cfg_f2_start);
          m_vbl = int'(cfg_vblank); m_pix = int'(cfg_pix_total);
          m_act = int'(cfg_pix_active); m_irql = int'(cfg_irq_line);
          m_intl = cfg_interlace;
        end
        bpl = 2 * m_pix;
        a2 = 2 * m_act;
        f = m_intl && l >= m_f2;
        v = (l - (f ? m_f2 : 0)) < m_vbl;
        for (int h = 0; h < bpl; h++) begin
          @(negedge clk);
          if (h < 4) begin
            e = codeb(h, f, v, 0); tg = (h == 3) ? "R2 R3 start code" : "R1 start code";
          end else if (h < 4 + a2) begin
            if (v) begin
              e = (h % 2) ? 16 : 128; tg = "R3 blank line";
            end else if (h % 2 == 0) begin
              raw = pat_c(ep); e = clipb(raw);
              tg = (raw == 0 || raw == 255) ? "R5 clip chroma" : "R4 chroma";
            end else begin
              raw = pat_y(ep); e = clipb(raw); ep++;
              tg = (raw == 0 || raw == 255) ? "R5 clip luma" : "R4 luma";
            end
          end else if (h < 8 + a2) begin
            e = codeb(h - 4 - a2, f, v, 1); tg = "R1 R2 end code";
          end else begin
            e = (h % 2) ? 16 : 128; tg = "R1 h blank";
          end
          if (chg) tg = {"R9 ", tg};
          chk(int'(vo_data) == e, tg, int'(vo_data), e);
          chk(vo_hsync == (h >= 4 + a2), "R6 hsync", int'(vo_hsync), int'(h >= 4 + a2));
          chk(vo_fsync == (l == 0), "R6 fsync", int'(vo_fsync), int'(l == 0));
          e = int'(en && h == bpl - 1 && (l == m_lines - 1 || (m_intl && l == m_f2 - 1)));
          chk(int'(irq_field) == e, "R7 field irq", int'(irq_field), e);
          e = int'(en && h == 0 && l == m_irql);
          chk(int'(irq_line) == e, "R8 line irq", int'(irq_line), e);
          if (chg && fr == 0 && l == 1 && h == 5) cfg_pix_total = 12'(chg_pix);
        end
        if (l >= m_lines - 1) done = 1;
        else l++;
      end
    end
    chk(pcnt == ep, "R4 pixel request count", pcnt, ep);
  endtask

  initial begin
    cfg_lines_total = '0; cfg_f2_start = '0; cfg_vblank = '0;
    cfg_pix_total = 12'd8; cfg_pix_active = '0; cfg_irq_line = '0;
    cfg_interlace = 1'b0; irq_field_en = 1'b0; irq_line_en = 1'b0;
    for (int i = 0; i < NCFG; i++) run(TBL[i], 2, 1'b1, 1'b0, 0);
    // R7 R8: interrupts disabled leave both pulses low
    run(TBL[0], 1, 1'b0, 1'b0, 0);
    // R9: pixel total rewritten mid-field applies from field two
    run(TBL[2], 2, 1'b1, 1'b1, 10);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired, actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule